// File: doc/BRIEF.md
# Watchdog-Routed Reset Controller

This block sits beside the clock and reset logic of a small chip. Software writes a control word that holds one reset line per peripheral: a 1 holds that peripheral in reset and a 0 releases it. The same word has a bit that starts a whole-chip reset and then clears itself. A second word, the routing word, decides where a watchdog expiry goes. It can go to the internal system reset, to an active-low reset pin, or to both. The routing word also sets how long the pin stays low, in whole microseconds.

Two small state machines produce the pulses. The system-reset machine has the states `SYS_IDLE` and `SYS_HOLD`. The transition `SYS_IDLE`→`SYS_HOLD` happens on a trigger. The transition `SYS_HOLD`→`SYS_IDLE` happens after 16 cycles. The pin machine has the states `PIN_IDLE` and `PIN_LOW`. The transition `PIN_IDLE`→`PIN_LOW` happens on an enabled watchdog rising edge. At that point the machine latches the period and restarts the microsecond divider. The transition `PIN_LOW`→`PIN_IDLE` happens on the tick that ends the last microsecond. The divider produces a one-cycle tick every `CLK_MHZ` cycles.

The register port is a plain select/write-enable/data port. Reads are combinational.

Top module: `rstgen_wdt_ctrl`

## Requirements
- R1: After `rst_n` the control word reads 0x0000_0400. `periph_rst` mirrors control bits 18:8, with `periph_rst[k]` taken from bit 8+k. The mapping is: k=10 serial-flash port, 9 audio serial, 8 two-wire bus, 7 NAND, 6 DMA, 5 GPIO, 4 UART, 3 voice PCM, 2 memory controller, 1 interrupt controller, 0 timer. So only `periph_rst[2]` is high after reset.
- R2: A write to the control word (`reg_sel`=0) stores bits 18:8, and the outputs update on the next cycle. Bits 31:19 and 7:0 always read 0, including bit 0 after it has been written with 1.
- R3: The routing word (`reg_sel`=1) reads 0xC003_0000 after reset. Its fields are: bit 31 enables the system-reset route, bit 30 enables the pin route, and bits 29:16 hold the period N. These fields can be written and read back. Bits 15:0 read 0.
- R4: Writing 1 to control bit 0 drives `sys_rst` high for exactly 16 cycles, starting the cycle after the write. Writing 0 there starts nothing.
- R5: A rising edge on `wdt_expire` while routing bit 31 is 1 drives `sys_rst` high for 16 cycles. While bit 31 is 0, the same edge leaves `sys_rst` low.
- R6: A rising edge on `wdt_expire` while routing bit 30 is 1 drives `rst_pin_n` low for exactly (N+1)·`CLK_MHZ` cycles, starting the next cycle. While bit 30 is 0, the pin stays high.
- R7: A rising edge that arrives while the pin is low is ignored. A `wdt_expire` level held high does not start a second pulse.
- R8: A change to the routing word during a pin pulse does not change that pulse. The new value applies from the next timeout.
- R9: A trigger that arrives while `sys_rst` is high does not lengthen the 16-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_MHZ` MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the routing word |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| wdt_expire | input | 1 | Watchdog timeout; its rising edge is the event |
| periph_rst | output | 11 | Per-peripheral reset lines |
| sys_rst | output | 1 | Internal system reset pulse |
| rst_pin_n | output | 1 | Active-low external reset pin |

## Verification
The register port is tested with a table of writes to both words: all ones, all zeros, alternating bits, and single fields. These patterns separate stored bits from reserved bits and show that the self-clearing bit reads back 0. Watchdog edges are then applied with four routing settings: both routes on, pin only, system only, and period 0. Each setting tells apart the two routes and the period arithmetic. Further directed cases cover a second edge during a pulse, a held level, a routing write during a pulse, and a repeated software trigger. These cases separate a latched period and a locked-out restart from a design that retriggers or reads the period live.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    typedef enum logic { PIN_IDLE, PIN_LOW  } pin_state_e;
    typedef enum logic { SYS_IDLE, SYS_HOLD } sys_state_e;

    localparam int PERIPH_N   = 11;
    localparam int PERIPH_LSB = 8;
    localparam int PERIOD_W   = 14;
    localparam int PERIOD_LSB = 16;
    localparam int EN_SYS_BIT = 31;
    localparam int EN_PIN_BIT = 30;
    localparam int SWRST_BIT  = 0;
    localparam logic [PERIPH_N-1:0] PERIPH_RST_INIT = 11'h004;
    localparam logic [PERIOD_W-1:0] PERIOD_INIT     = 14'd3;
endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
    parameter int CLK_MHZ = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_MHZ - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (clr || tick)   cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (CLK_MHZ > 1) begin : g_spacing
            // R6: ticks are spaced, never back to back
            a_r6_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/pin_pulse_fsm.sv
module pin_pulse_fsm
    import rstc_pkg::*;
#(
    parameter int PW = PERIOD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] period,
    input  logic          tick,
    output logic          tick_clr,
    output logic          pin_n
);
    pin_state_e    state, state_nx;
    logic [PW-1:0] us_left;

    always_comb begin
        state_nx = state;
        unique case (state)
            PIN_IDLE: if (start)                     state_nx = PIN_LOW;
            PIN_LOW:  if (tick && us_left == '0)     state_nx = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= PIN_IDLE;
            us_left <= '0;
        end else begin
            state <= state_nx;
            if (state == PIN_IDLE && start)  us_left <= period;
            else if (state == PIN_LOW && tick && us_left != '0)
                                             us_left <= us_left - 1'b1;
        end
    end

    always_comb begin
        pin_n    = (state != PIN_LOW);
        tick_clr = (state == PIN_IDLE) && start;
    end

    // R6: the pin only falls after a start request
    a_r6_fall_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_n) |-> $past(start));
    // R7: a start while low keeps the pin low unless the pulse is ending
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_n && start && !tick) |=> !pin_n);
endmodule

// File: rtl/sys_pulse_fsm.sv
module sys_pulse_fsm
    import rstc_pkg::*;
#(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic sys_rst
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

    sys_state_e    state, state_nx;
    logic [CW-1:0] left;

    always_comb begin
        state_nx = state;
        unique case (state)
            SYS_IDLE: if (trig)        state_nx = SYS_HOLD;
            SYS_HOLD: if (left == '0)  state_nx = SYS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SYS_IDLE;
            left  <= '0;
        end else begin
            state <= state_nx;
            if (state == SYS_IDLE && trig) left <= LOAD;
            else if (state == SYS_HOLD && left != '0) left <= left - 1'b1;
        end
    end

    always_comb sys_rst = (state == SYS_HOLD);

    // R4/R5: the pulse rises only in response to a trigger
    a_r5_rise_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(trig));
    // R9: a trigger mid-pulse does not restart the count
    a_r9_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && trig && left == '0) |=> !sys_rst);
endmodule

// File: rtl/rstgen_wdt_ctrl.sv
module rstgen_wdt_ctrl
    import rstc_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int SYS_LEN  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_sel,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                wdt_expire,
    output logic [PERIPH_N-1:0] periph_rst,
    output logic                sys_rst,
    output logic                rst_pin_n
);
    localparam int PERIPH_MSB = PERIPH_LSB + PERIPH_N - 1;
    localparam int PERIOD_MSB = PERIOD_LSB + PERIOD_W - 1;

    logic [PERIPH_N-1:0] periph_q;
    logic                en_sys_q, en_pin_q;
    logic [PERIOD_W-1:0] period_q;
    logic                wdt_q, wdt_rise;
    logic                sw_rst, sys_trig, pin_start;
    logic                tick, tick_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            periph_q <= PERIPH_RST_INIT;
            en_sys_q <= 1'b1;
            en_pin_q <= 1'b1;
            period_q <= PERIOD_INIT;
            wdt_q    <= 1'b0;
        end else begin
            wdt_q <= wdt_expire;
            if (reg_we && !reg_sel)
                periph_q <= reg_wdata[PERIPH_MSB:PERIPH_LSB];
            if (reg_we && reg_sel) begin
                en_sys_q <= reg_wdata[EN_SYS_BIT];
                en_pin_q <= reg_wdata[EN_PIN_BIT];
                period_q <= reg_wdata[PERIOD_MSB:PERIOD_LSB];
            end
        end
    end

    always_comb begin
        wdt_rise  = wdt_expire && !wdt_q;
        sw_rst    = reg_we && !reg_sel && reg_wdata[SWRST_BIT];
        sys_trig  = sw_rst || (wdt_rise && en_sys_q);
        pin_start = wdt_rise && en_pin_q;
        if (reg_sel)
            reg_rdata = {en_sys_q, en_pin_q, period_q, 16'h0000};
        else
            reg_rdata = {13'h0000, periph_q, 8'h00};
        periph_rst = periph_q;
    end

    us_tick_gen #(.CLK_MHZ(CLK_MHZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
    );

    pin_pulse_fsm #(.PW(PERIOD_W)) u_pin (
        .clk(clk), .rst_n(rst_n), .start(pin_start), .period(period_q),
        .tick(tick), .tick_clr(tick_clr), .pin_n(rst_pin_n)
    );

    sys_pulse_fsm #(.LEN(SYS_LEN)) u_sys (
        .clk(clk), .rst_n(rst_n), .trig(sys_trig), .sys_rst(sys_rst)
    );

    // R2: the control word never returns reserved or self-clearing bits
    a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[7:0] == 8'h00 && reg_rdata[31:19] == 13'h0));
    // R4: an idle block answers a software reset write on the next cycle
    a_r4_sw_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_sel && reg_wdata[0] && !sys_rst) |=> sys_rst);
    // R5: a disabled system route never lets a watchdog edge reach sys_rst
    a_r5_route_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst && wdt_expire && !wdt_q && !en_sys_q && !(reg_we && !reg_sel && reg_wdata[0]))
        |=> !sys_rst);
    // R6: a disabled pin route keeps an idle pin high
    a_r6_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pin_n && !en_pin_q) |=> rst_pin_n);
endmodule

// File: tb/tb_rstgen_wdt_ctrl.sv
module tb_rstgen_wdt_ctrl;
    localparam int MHZ = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wdt_expire = 1'b0;
    logic [10:0] periph_rst;
    logic        sys_rst, rst_pin_n;

    int checks = 0;
    int errors = 0;
    int sys_cnt = 0;
    int pin_cnt = 0;

    always #5 clk = ~clk;

    rstgen_wdt_ctrl #(.CLK_MHZ(MHZ), .SYS_LEN(16)) dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_expire(wdt_expire),
        .periph_rst(periph_rst), .sys_rst(sys_rst), .rst_pin_n(rst_pin_n)
    );

    always @(negedge clk) begin
        if (sys_rst)    sys_cnt = sys_cnt + 1;
        if (!rst_pin_n) pin_cnt = pin_cnt + 1;
    end

    localparam int NV = 6;
    localparam logic        VEC_SEL [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic [31:0] VEC_WD  [NV] = '{32'hFFFF_FFFE, 32'h0000_0000, 32'hAAAA_AAAA,
                                             32'hFFFF_FFFF, 32'h5555_5555, 32'hC003_0000};
    localparam logic [31:0] VEC_RD  [NV] = '{32'h0007_FF00, 32'h0000_0000, 32'h0002_AA00,
                                             32'hFFFF_0000, 32'h5555_0000, 32'hC003_0000};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clear_counts();
        @(negedge clk);
        #1;
        sys_cnt = 0; pin_cnt = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R3 reset values
        reg_sel = 1'b0; #1;
        chk("R1 ctrl reset", reg_rdata, 32'h0000_0400);
        chk("R1 periph reset", {21'h0, periph_rst}, 32'h0000_0004);
        chk("R1 sys idle", {31'h0, sys_rst}, 32'h0);
        chk("R1 pin idle", {31'h0, rst_pin_n}, 32'h1);
        reg_sel = 1'b1; #1;
        chk("R3 cfg reset", reg_rdata, 32'hC003_0000);

        // table: R2 / R3 write and readback
        for (int i = 0; i < NV; i++) begin
            wr(VEC_SEL[i], VEC_WD[i]);
            reg_sel = VEC_SEL[i]; #1;
            chk(VEC_SEL[i] ? "R3 cfg rw" : "R2 ctrl rw", reg_rdata, VEC_RD[i]);
            if (!VEC_SEL[i])
                chk("R2 periph out", {21'h0, periph_rst}, {21'h0, VEC_RD[i][18:8]});
        end
        chk("R4 no sw pulse from zero bit", sys_cnt, 0);

        // R5/R6/R7: both routes, N=3, level held high
        clear_counts();
        wdt_expire = 1'b1;
        idle(600);
        chk("R6 pin width N=3", pin_cnt, 4 * MHZ);
        chk("R5 sys width", sys_cnt, 16);
        chk("R7 held level single pulse", {31'h0, rst_pin_n}, 32'h1);
        wdt_expire = 1'b0; idle(3);

        // R6 period 0
        wr(1'b1, 32'hC000_0000);
        clear_counts();
        wdt_expire = 1'b1; idle(3); wdt_expire = 1'b0;
        idle(200);
        chk("R6 pin width N=0", pin_cnt, MHZ);

        // R6 pin route off, system only
        wr(1'b1, 32'h8003_0000);
        clear_counts();
        wdt_expire = 1'b1; idle(3); wdt_expire = 1'b0;
        idle(600);
        chk("R6 pin route off", pin_cnt, 0);
        chk("R5 sys route on", sys_cnt, 16);

        // R5 system route off; R7 second edge mid-pulse
        wr(1'b1, 32'h4003_0000);
        clear_counts();
        wdt_expire = 1'b1; idle(50); wdt_expire = 1'b0;
        idle(100); wdt_expire = 1'b1; idle(5); wdt_expire = 1'b0;
        idle(600);
        chk("R5 sys route off", sys_cnt, 0);
        chk("R7 edge during pulse ignored", pin_cnt, 4 * MHZ);

        // R8 config write mid-pulse
        clear_counts();
        wdt_expire = 1'b1; idle(3); wdt_expire = 1'b0;
        idle(50);
        wr(1'b1, 32'h4000_0000);
        idle(600);
        chk("R8 pulse keeps latched period", pin_cnt, 4 * MHZ);
        clear_counts();
        wdt_expire = 1'b1; idle(3); wdt_expire = 1'b0;
        idle(200);
        chk("R8 next timeout uses new period", pin_cnt, MHZ);

        // R4 software reset, R9 retrigger does not extend
        clear_counts();
        wr(1'b0, 32'h0000_0501);
        reg_sel = 1'b0; #1;
        chk("R2 bit0 reads zero", reg_rdata, 32'h0000_0500);
        chk("R2 periph after sw write", {21'h0, periph_rst}, 32'h0000_0005);
        idle(30);
        chk("R4 sw pulse width", sys_cnt, 16);
        chk("R4 sw no pin", pin_cnt, 0);
        clear_counts();
        wr(1'b0, 32'h0000_0001);
        idle(4);
        wr(1'b0, 32'h0000_0001);
        idle(30);
        chk("R9 retrigger no extend", sys_cnt, 16);

        finish_run();
    end
endmodule